// File: doc/BRIEF.md
# Dual-Channel Tone Presence Qualifier

This block turns a raw, per-channel "tone present" flag into a clean, qualified presence output for each of two channels. The raw flag arrives from an upstream comparator and pulse-length measurement stage. Each channel's flag passes through a synchronizer. A slow time base divides the system clock down to a 1 ms tick, and all qualification is counted in those ticks.

There are two output formats, and one shared select input picks the format for both channels. In the follower format the output copies the raw decision once the new value has held for a short settle time. In the packet format the output changes state only when the opposite condition has been seen on enough ticks of a fixed observation window. Those ticks do not need to be consecutive, so short dropouts inside a burst do not reverse the output. A shared high-impedance request input clears a per-channel drive qualifier, which the pad ring uses to float the pins. This block has no tristate driver of its own.

Top module: `tone_qualifier_dual`

## Requirements
- R1: The tick time base fires once every CLK_HZ/TICK_HZ clock cycles. Every qualification count advances only on a tick.
- R2: In follower format (follow_sel = 1), a channel's tone_out takes the value of its synchronized raw flag on the tick where the flag has differed from tone_out for FOLLOW_TICKS consecutive ticks.
- R3: In follower format, a run of mismatching ticks shorter than FOLLOW_TICKS that ends with a matching tick leaves tone_out unchanged and restarts the run count.
- R4: In packet format (follow_sel = 0), a low output goes high on the tick where the number of tone ticks in the current window reaches PKT_THRESH. The tone ticks need not be consecutive.
- R5: In packet format, a high output goes low on the tick where the number of no-tone ticks in the current window reaches PKT_THRESH. The no-tone ticks need not be consecutive.
- R6: Packet windows are WIN_TICKS ticks long. The accumulated count is discarded at the end of each window, so mismatch ticks split across two windows never combine.
- R7: follow_sel = 1 routes the follower result to both tone_out bits. follow_sel = 0 routes the packet result to both. Both units keep running whichever format is selected.
- R8: Any change of follow_sel clears all accumulation counts and restarts the tick divider and the window position. The first tick after the change comes TICK_DIV cycles later.
- R9: hiz_req = 1 drives every tone_drive bit to 0, and hiz_req = 0 drives every bit to 1. The request has no effect on tone_out or on the qualification state.
- R10: During reset both tone_out bits are 0 and all counts are cleared.
- R11: The two channels are qualified independently. A pattern on one channel's raw flag does not move the other channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (3.579545 MHz by default) |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_tone | input | NUM_CH | Raw tone-detect flag per channel, 1 = tone |
| follow_sel | input | 1 | Output format: 1 = follower, 0 = packet |
| hiz_req | input | 1 | 1 = release both output pins to high impedance |
| tone_out | output | NUM_CH | Qualified tone presence per channel |
| tone_drive | output | NUM_CH | Pad drive qualifier per channel, 1 = drive tone_out |

## Verification
The bench builds the block with an 8000 Hz clock setting and a 1000 Hz tick, which gives an 8-cycle tick. It also uses a 12-tick window, a threshold of 10, a follower settle of 3 ticks and two synchronizer stages. With a tick this short, every window boundary, threshold crossing and mode-change restart falls within a few hundred cycles, and each can be checked at an exact tick. Because the threshold is only two below the window length, a short dropout or a split across two windows decides whether the output flips. Because the bench keeps the synchronizer delay below half a tick, raw changes placed mid-tick land on a known tick.

// File: rtl/tq_pkg.sv
package tq_pkg;

   // Output format selector shared by every channel
   typedef enum logic {
      FMT_PACKET = 1'b0,
      FMT_FOLLOW = 1'b1
   } out_fmt_e;

   // Bits needed to hold values 0..max_val
   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/tq_tick_gen.sv
module tq_tick_gen #(
   parameter int unsigned DIV = 3579
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int unsigned CW = tq_pkg::cnt_width(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("tq_tick_gen: DIV must be at least 2");
   end

   logic [CW-1:0] div_cnt;

   assign tick = (div_cnt == CW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_cnt <= '0;
      else if (clr || tick)
         div_cnt <= '0;
      else
         div_cnt <= div_cnt + 1'b1;
   end

   AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R1
   AST_TICK_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !tick); // R8

endmodule

// File: rtl/tq_window_timer.sv
module tq_window_timer #(
   parameter int unsigned WIN_TICKS = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic win_last
);
   localparam int unsigned PW = tq_pkg::cnt_width(WIN_TICKS - 1);

   logic [PW-1:0] pos;

   // High on the final tick of the observation window
   assign win_last = tick && (pos == PW'(WIN_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos <= '0;
      else if (clr || win_last)
         pos <= '0;
      else if (tick)
         pos <= pos + 1'b1;
   end

   AST_WIN_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      win_last |=> (pos == '0)); // R6
   AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (pos <= PW'(WIN_TICKS - 1))); // R6

endmodule

// File: rtl/tq_follower.sv
module tq_follower #(
   parameter int unsigned FOLLOW_TICKS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic raw,
   output logic q
);
   localparam int unsigned CW = tq_pkg::cnt_width(FOLLOW_TICKS);

   logic [CW-1:0] run_cnt;
   logic          differ;

   assign differ = (raw != q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         q       <= 1'b0;
      end else if (clr) begin
         run_cnt <= '0;
      end else if (tick) begin
         if (!differ)
            run_cnt <= '0;
         else if (run_cnt == CW'(FOLLOW_TICKS - 1)) begin
            q       <= raw;
            run_cnt <= '0;
         end else
            run_cnt <= run_cnt + 1'b1;
      end
   end

   AST_FOL_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (q != $past(q)) |-> $past(tick)); // R2
   AST_FOL_RUN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr && !differ) |=> (run_cnt == '0)); // R3
   AST_FOL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (run_cnt == '0)); // R8

endmodule

// File: rtl/tq_packet.sv
module tq_packet #(
   parameter int unsigned PKT_THRESH = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic win_last,
   input  logic raw,
   output logic q
);
   localparam int unsigned CW = tq_pkg::cnt_width(PKT_THRESH);

   logic [CW-1:0] acc;
   logic          opposite;
   logic          reach;

   assign opposite = (raw != q);
   assign reach    = opposite && (acc == CW'(PKT_THRESH - 1));

   // Flip takes priority over the window-end discard
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         q   <= 1'b0;
      end else if (clr) begin
         acc <= '0;
      end else if (tick) begin
         if (reach) begin
            q   <= ~q;
            acc <= '0;
         end else if (win_last)
            acc <= '0;
         else if (opposite)
            acc <= acc + 1'b1;
      end
   end

   AST_PKT_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (q != $past(q)) |-> $past(tick)); // R4
   AST_PKT_BELOW_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (acc < CW'(PKT_THRESH))); // R5
   AST_PKT_WIN_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (win_last && !clr) |=> (acc == '0)); // R6
   AST_PKT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc == '0)); // R8

endmodule

// File: rtl/tone_qualifier_dual.sv
module tone_qualifier_dual
   import tq_pkg::*;
#(
   parameter int unsigned NUM_CH       = 2,
   parameter int unsigned CLK_HZ       = 3579545,
   parameter int unsigned TICK_HZ      = 1000,
   parameter int unsigned WIN_TICKS    = 48,
   parameter int unsigned PKT_THRESH   = 40,
   parameter int unsigned FOLLOW_TICKS = 10,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] raw_tone,
   input  logic              follow_sel,
   input  logic              hiz_req,
   output logic [NUM_CH-1:0] tone_out,
   output logic [NUM_CH-1:0] tone_drive
);
   localparam int unsigned TICK_DIV = CLK_HZ / TICK_HZ;

   // Elaboration-time parameter checks
   if (NUM_CH < 1) begin : g_bad_ch
      $error("tone_qualifier_dual: NUM_CH must be at least 1");
   end
   if (TICK_DIV < 2) begin : g_bad_div
      $error("tone_qualifier_dual: CLK_HZ must be at least twice TICK_HZ");
   end
   if ((PKT_THRESH > WIN_TICKS) || (2 * PKT_THRESH <= WIN_TICKS)) begin : g_bad_thresh
      $error("tone_qualifier_dual: PKT_THRESH must exceed half the window and fit inside it");
   end
   if (FOLLOW_TICKS < 1) begin : g_bad_follow
      $error("tone_qualifier_dual: FOLLOW_TICKS must be at least 1");
   end

   // Raw flag synchronizer, omitted when SYNC_STAGES is zero
   logic [NUM_CH-1:0] raw_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign raw_s = raw_tone;
   end else begin : g_sync
      logic [NUM_CH-1:0] stg [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= raw_tone;
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign raw_s = stg[SYNC_STAGES-1];
   end

   // Format tracking; a change restarts all timing
   out_fmt_e fmt_in;
   out_fmt_e fmt_q;
   logic     fmt_chg;

   assign fmt_in  = follow_sel ? FMT_FOLLOW : FMT_PACKET;
   assign fmt_chg = (fmt_in != fmt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fmt_q <= FMT_PACKET;
      else
         fmt_q <= fmt_in;
   end

   logic tick;
   logic win_last;

   tq_tick_gen #(
      .DIV (TICK_DIV)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (fmt_chg),
      .tick  (tick)
   );

   tq_window_timer #(
      .WIN_TICKS (WIN_TICKS)
   ) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (fmt_chg),
      .tick     (tick),
      .win_last (win_last)
   );

   logic [NUM_CH-1:0] fol_q;
   logic [NUM_CH-1:0] pkt_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      tq_follower #(
         .FOLLOW_TICKS (FOLLOW_TICKS)
      ) u_fol (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (fmt_chg),
         .tick  (tick),
         .raw   (raw_s[c]),
         .q     (fol_q[c])
      );

      tq_packet #(
         .PKT_THRESH (PKT_THRESH)
      ) u_pkt (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (fmt_chg),
         .tick     (tick),
         .win_last (win_last),
         .raw      (raw_s[c]),
         .q        (pkt_q[c])
      );

      assign tone_out[c] = (fmt_q == FMT_FOLLOW) ? fol_q[c] : pkt_q[c];
   end

   assign tone_drive = {NUM_CH{~hiz_req}};

   AST_FMT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_chg |=> (fmt_q == $past(fmt_in))); // R7
   AST_OUT_MOVES_ON_TICK_OR_FMT: assert property (@(posedge clk) disable iff (!rst_n)
      (tone_out != $past(tone_out)) |-> ($past(tick) || $past(fmt_chg))); // R1

endmodule

// File: tb/tone_qualifier_dual_bench.sv
`timescale 1ns/1ps
module tone_qualifier_dual_bench;

   localparam int unsigned NCH  = 2;
   localparam int unsigned DIVB = 8;   // 8000 / 1000

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] raw_tone = '0;
   logic           follow_sel = 1'b0;
   logic           hiz_req = 1'b0;
   logic [NCH-1:0] tone_out;
   logic [NCH-1:0] tone_drive;

   int total = 0;
   int bad   = 0;
   int since_e0 = 0;

   always #2.5 clk = ~clk;

   tone_qualifier_dual #(
      .NUM_CH       (NCH),
      .CLK_HZ       (8000),
      .TICK_HZ      (1000),
      .WIN_TICKS    (12),
      .PKT_THRESH   (10),
      .FOLLOW_TICKS (3),
      .SYNC_STAGES  (2)
   ) u_tone_qualifier_dual (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw_tone   (raw_tone),
      .follow_sel (follow_sel),
      .hiz_req    (hiz_req),
      .tone_out   (tone_out),
      .tone_drive (tone_drive)
   );

   task automatic check(input string req, input logic [NCH-1:0] act,
                        input logic [NCH-1:0] exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   // Advance to the falling edge after rising edge E0+m
   task automatic step_to(input int m);
      while (since_e0 < m) begin
         @(negedge clk);
         since_e0++;
      end
   endtask

   // Two format changes; the second rising edge becomes E0
   task automatic restart(input logic fmt);
      follow_sel = ~fmt;
      @(negedge clk);
      follow_sel = fmt;
      @(negedge clk);
      since_e0 = 0;
   endtask

   task automatic settle_low();
      raw_tone = '0;
      restart(1'b0);
      step_to(30 * DIVB);
      check("R5", tone_out, 2'b00, "settle to no tone");
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R10", tone_out, 2'b00, "outputs during reset");
      check("R9", tone_drive, 2'b11, "drive enabled during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", tone_out, 2'b00, "outputs after reset");
   endtask

   task automatic t_follower();
      raw_tone = '0;
      restart(1'b1);
      step_to(4);  raw_tone = 2'b01;
      step_to(20); check("R2", tone_out, 2'b00, "before settle");
      step_to(28); check("R2", tone_out, 2'b01, "after settle");
      step_to(36); raw_tone = 2'b10;          // two-tick glitch on both
      step_to(52); raw_tone = 2'b01;
      step_to(76); check("R3", tone_out, 2'b01, "short glitch ignored");
      raw_tone = 2'b00;
      step_to(92); check("R2", tone_out, 2'b01, "de-respond pending");
      step_to(100); check("R2", tone_out, 2'b00, "de-responded");
   endtask

   task automatic t_packet();
      settle_low();
      raw_tone = 2'b11;
      restart(1'b0);
      step_to(52); raw_tone = 2'b01;          // ch1 drops out for ticks 7,8
      step_to(68); raw_tone = 2'b11;
      step_to(76); check("R4", tone_out, 2'b00, "below threshold at tick 9");
      step_to(84); check("R4", tone_out, 2'b01, "ch0 responds at tick 10");
      step_to(92); check("R11", tone_out, 2'b01, "ch1 still counting");
      step_to(100); check("R4", tone_out, 2'b11, "ch1 responds despite dropout");
      raw_tone = 2'b00;
      step_to(116); raw_tone = 2'b10;         // ch1 tone blip on tick 15
      step_to(124); raw_tone = 2'b00;
      step_to(172); check("R5", tone_out, 2'b11, "both still high at tick 21");
      step_to(180); check("R5", tone_out, 2'b10, "ch0 de-responds at tick 22");
      step_to(188); check("R5", tone_out, 2'b00, "ch1 de-responds at tick 23");
   endtask

   task automatic t_window();
      raw_tone = 2'b01;
      restart(1'b0);
      step_to(76);  raw_tone = 2'b00;         // 9 tone ticks in window 1
      step_to(100); raw_tone = 2'b01;         // 9 tone ticks in window 2
      step_to(172); raw_tone = 2'b00;
      step_to(180); check("R6", tone_out, 2'b00, "split count no flip");
      step_to(204); check("R6", tone_out, 2'b00, "still no flip after window");
   endtask

   task automatic t_mode_clear();
      raw_tone = 2'b01;
      restart(1'b0);
      step_to(68);                             // eight tone ticks counted
      restart(1'b0);
      step_to(20); check("R8", tone_out, 2'b00, "count discarded");
      step_to(76); check("R8", tone_out, 2'b00, "tick 9 after restart");
      step_to(84); check("R8", tone_out, 2'b01, "tick 10 after restart");
   endtask

   task automatic t_mode_mux();
      raw_tone = 2'b00;
      step_to(124);
      check("R7", tone_out, 2'b01, "packet output holds");
      follow_sel = 1'b1;
      @(negedge clk);
      check("R7", tone_out, 2'b00, "follower output selected");
   endtask

   task automatic t_hiz();
      raw_tone = 2'b11;
      hiz_req  = 1'b1;
      @(negedge clk);
      check("R9", tone_drive, 2'b00, "drive released");
      repeat (6 * DIVB) @(negedge clk);
      check("R9", tone_out, 2'b11, "qualification runs while released");
      check("R9", tone_drive, 2'b00, "drive still released");
      hiz_req = 1'b0;
      @(negedge clk);
      check("R9", tone_drive, 2'b11, "drive restored");
      check("R9", tone_out, 2'b11, "output unaffected");
   endtask

   initial begin
      t_reset();
      t_follower();
      t_packet();
      t_window();
      t_mode_clear();
      t_mode_mux();
      t_hiz();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule